// File: doc/BRIEF.md
# Shared-Memory Segment Buffer Manager

This block owns a pool of equal-sized segments in a shared packet memory and hands them out to several clients on request. Clients talk to it with single 32-bit request words on a valid/ready stream: an allocate word asks for a segment, and a release word hands a segment back once the consumer has drained the packet from it. Every allocate and release for the pool goes through this one manager, so it is the single point of truth for which segment is in use.

Free segments sit in a FIFO of indices that holds every index after reset. An allocate pops the oldest free index and writes a context word for that segment into shared memory through a write-only port. Only after that write has been accepted does the manager send a reply to the requesting node with the segment's base address. An allocate that finds no free segment gets an immediate failure reply. A bitmap of in-use segments guards releases: returning a segment that is already free, or naming one outside the pool, changes nothing and raises a one-cycle error pulse. Requests are handled strictly one at a time.

Top module: `seg_buf_mgr`

## Requirements
- R1: After reset all NUM_SEG segments are free, `req_ready` is 1, and `rsp_valid`, `mem_wvalid` and `rel_err` are 0.
- R2: A request word carries the operation code in bits [1:0] (2'b01 allocate, 2'b10 release), the requesting node ID in bits [9:2], and for a release the segment index in bits [31:16]; bits [15:10] are ignored.
- R3: An allocate is granted the oldest free index: after reset the order is 0, 1, ..., NUM_SEG-1, and each released index joins the tail of that order. The segment address is BASE_ADDR + index * SEG_BYTES.
- R4: A successful allocate raises `mem_wvalid` in the cycle after acceptance, with `mem_waddr` equal to the segment address and `mem_wdata` = {node ID in [31:24], 8'h00 in [23:16], index in [15:0]}, held stable until `mem_wready` is 1.
- R5: The reply for a successful allocate rises in the cycle after the write handshake, carries the requester's node ID, the segment address and `rsp_fail` = 0, and is held stable until `rsp_ready` is 1.
- R6: An allocate while no segment is free makes no memory write and raises the reply in the cycle after acceptance with `rsp_fail` = 1 and `rsp_addr` = 0.
- R7: A release of an allocated index makes that index free again and produces neither a reply nor a memory write.
- R8: A release of an index that is free, or that is NUM_SEG or larger, leaves the free set unchanged and drives `rel_err` to 1 for exactly the cycle after acceptance.
- R9: Request words with operation code 2'b00 or 2'b11 are accepted and have no effect.
- R10: From the acceptance of an allocate until its reply handshake, `req_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request word present |
| req_ready | output | 1 | Manager can take a request word |
| req_data | input | 32 | Request word (operation, node ID, segment index) |
| mem_wvalid | output | 1 | Context write present |
| mem_wready | input | 1 | Shared memory accepts the context write |
| mem_waddr | output | ADDR_W | Context write address (segment base) |
| mem_wdata | output | 32 | Context word |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Network accepts the reply |
| rsp_node | output | 8 | Node ID the reply is addressed to |
| rsp_fail | output | 1 | Allocation failed, no segment free |
| rsp_addr | output | ADDR_W | Granted segment base address, zero on failure |
| rel_err | output | 1 | One-cycle pulse on a rejected release |

## Verification
The two functions that can meet in one cycle are an outgoing reply held by back-pressure and a fresh request waiting at the input. The bench provokes this by stalling `rsp_ready` for several cycles while it drives a release word for the segment just granted, and judges that `req_ready` stays low throughout, the reply stays stable, and the release is taken only after the reply handshake, after which the freed index reappears at the tail of the allocation order. Random sequences repeat the overlap with random stall lengths on both the memory and reply sides, checked against a bench model of the free order and the in-use set.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
  // Request word layout; fixed by the message format
  localparam int unsigned OP_LO   = 0;
  localparam int unsigned OP_HI   = 1;
  localparam int unsigned NODE_LO = 2;
  localparam int unsigned NODE_HI = 9;
  localparam int unsigned SIDX_LO = 16;
  localparam int unsigned SIDX_HI = 31;
  localparam int unsigned NODE_W  = NODE_HI - NODE_LO + 1;
  localparam int unsigned SIDX_W  = SIDX_HI - SIDX_LO + 1;
  localparam int unsigned WORD_W  = 32;

  localparam logic [1:0] OP_ALLOC   = 2'b01;
  localparam logic [1:0] OP_RELEASE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_REPLY = 2'd2
  } sbm_state_e;
endpackage

// File: rtl/sbm_free_fifo.sv
`timescale 1ns/1ps
module sbm_free_fifo #(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic             empty,
  output logic [IDX_W:0]   count
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1);
  localparam logic [IDX_W:0]   FULL = (IDX_W+1)'(NUM_SEG);

  logic [IDX_W-1:0] slot_q [NUM_SEG];
  logic [IDX_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [IDX_W:0]   cnt_q, cnt_d;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? bump(rd_q) : rd_q;
    wr_d  = push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= FULL;
    end else if (push || pop) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // Each slot resets to its own index, so the list starts full
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= IDX_W'(g);
      end else if (push && (wr_q == IDX_W'(g))) begin
        slot_q[g] <= push_idx;
      end
    end
  end

  assign head_idx = slot_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign count    = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < FULL));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/sbm_alloc_map.sv
`timescale 1ns/1ps
module sbm_alloc_map #(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_SEG-1:0] in_use
);
  logic [NUM_SEG-1:0] use_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set && (set_idx == IDX_W'(g));
    assign hit_clr = clr && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_q[g] <= 1'b0;
      end else if (hit_set || hit_clr) begin
        use_q[g] <= hit_set;
      end
    end
  end

  assign in_use = use_q;

  p_set_only_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !use_q[set_idx]);
  p_clr_only_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> use_q[clr_idx]);
endmodule

// File: rtl/sbm_ctrl.sv
`timescale 1ns/1ps
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int unsigned NUM_SEG   = 16,
  parameter int unsigned IDX_W     = $clog2(NUM_SEG),
  parameter int unsigned SEG_BYTES = 256,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WORD_W-1:0]  req_data,
  output logic               mem_wvalid,
  input  logic               mem_wready,
  output logic [ADDR_W-1:0]  mem_waddr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [NODE_W-1:0]  rsp_node,
  output logic               rsp_fail,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rel_err,
  input  logic               fifo_empty,
  input  logic [IDX_W-1:0]   fifo_head,
  input  logic [NUM_SEG-1:0] in_use,
  output logic               pop,
  output logic               push,
  output logic [IDX_W-1:0]   push_idx
);
  sbm_state_e        state_q, state_d;
  logic [NODE_W-1:0] node_q;
  logic [IDX_W-1:0]  idx_q;
  logic              fail_q;
  logic              err_q, err_d;
  logic              acc, is_alloc, is_rel, load, rel_ok, in_range;
  logic [SIDX_W-1:0] sidx;
  logic [ADDR_W-1:0] seg_addr;
  logic              unused_fmt;

  assign unused_fmt = ^req_data[SIDX_LO-1:NODE_HI+1];

  assign req_ready = (state_q == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign is_alloc  = (req_data[OP_HI:OP_LO] == OP_ALLOC);
  assign is_rel    = (req_data[OP_HI:OP_LO] == OP_RELEASE);
  assign sidx      = req_data[SIDX_HI:SIDX_LO];
  assign in_range  = (sidx < SIDX_W'(NUM_SEG));
  assign rel_ok    = in_range && in_use[sidx[IDX_W-1:0]];
  assign load      = acc && is_alloc;

  assign pop      = load && !fifo_empty;
  assign push     = acc && is_rel && rel_ok;
  assign push_idx = sidx[IDX_W-1:0];
  assign err_d    = acc && is_rel && !rel_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load)       state_d = fifo_empty ? ST_REPLY : ST_WRITE;
      ST_WRITE: if (mem_wready) state_d = ST_REPLY;
      ST_REPLY: if (rsp_ready)  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
      idx_q  <= '0;
      fail_q <= 1'b0;
    end else if (load) begin
      node_q <= req_data[NODE_HI:NODE_LO];
      idx_q  <= fifo_head;
      fail_q <= fifo_empty;
    end
  end

  assign seg_addr   = BASE_ADDR + ADDR_W'(idx_q) * ADDR_W'(SEG_BYTES);
  assign mem_wvalid = (state_q == ST_WRITE);
  assign mem_waddr  = seg_addr;
  assign mem_wdata  = {node_q, 8'h00, SIDX_W'(idx_q)};
  assign rsp_valid  = (state_q == ST_REPLY);
  assign rsp_node   = node_q;
  assign rsp_fail   = fail_q;
  assign rsp_addr   = fail_q ? '0 : seg_addr;
  assign rel_err    = err_q;

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_node)));
  p_reply_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_fail) |-> $past(mem_wvalid && mem_wready));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_wvalid) |-> !req_ready);
endmodule

// File: rtl/seg_buf_mgr.sv
`timescale 1ns/1ps
module seg_buf_mgr
  import sbm_pkg::*;
#(
  parameter int unsigned NUM_SEG   = 16,
  parameter int unsigned SEG_BYTES = 256,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_data,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [31:0]       mem_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_node,
  output logic              rsp_fail,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rel_err
);
  localparam int unsigned IDX_W = $clog2(NUM_SEG);

  logic               pop, push, fifo_empty;
  logic [IDX_W-1:0]   push_idx, fifo_head;
  logic [IDX_W:0]     free_cnt;
  logic [NUM_SEG-1:0] in_use;

  sbm_free_fifo #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_free (
    .clk(clk), .rst_n(rst_n), .push(push), .push_idx(push_idx), .pop(pop),
    .head_idx(fifo_head), .empty(fifo_empty), .count(free_cnt)
  );

  sbm_alloc_map #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .set(pop), .set_idx(fifo_head),
    .clr(push), .clr_idx(push_idx), .in_use(in_use)
  );

  sbm_ctrl #(
    .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .SEG_BYTES(SEG_BYTES),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
    .rsp_fail(rsp_fail), .rsp_addr(rsp_addr), .rel_err(rel_err),
    .fifo_empty(fifo_empty), .fifo_head(fifo_head), .in_use(in_use),
    .pop(pop), .push(push), .push_idx(push_idx)
  );

  p_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_use) + int'(free_cnt)) == NUM_SEG);
  p_fail_only_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_fail |-> free_cnt == '0);
endmodule

// File: tb/seg_buf_mgr_tb.sv
`timescale 1ns/1ps
module seg_buf_mgr_tb;
  localparam int unsigned NSEG = 16;
  localparam int unsigned SEGB = 256;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_data = '0;
  logic        mem_wready = 1'b0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, mem_wvalid, rsp_valid, rsp_fail, rel_err;
  logic [31:0] mem_waddr, mem_wdata, rsp_addr;
  logic [7:0]  rsp_node;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  int fq[$];
  bit used_m[NSEG];

  always #4 clk = ~clk;

  seg_buf_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_node(rsp_node), .rsp_fail(rsp_fail),
    .rsp_addr(rsp_addr), .rel_err(rel_err)
  );

  function automatic logic [31:0] seg_addr(input int idx);
    return BASE + 32'(idx) * 32'(SEGB);
  endfunction

  function automatic logic [31:0] ctx_word(input logic [7:0] node, input int idx);
    return {node, 8'h00, 16'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = w;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Allocate; optionally queue a release of the granted index during the reply stall
  task automatic do_alloc(input logic [7:0] node, input int wst, input int rst, input bit overlap);
    bit exp_fail;
    int exp_idx;
    logic [31:0] ea;
    exp_fail = (fq.size() == 0);
    exp_idx  = exp_fail ? 0 : fq[0];
    ea       = exp_fail ? 32'h0 : seg_addr(exp_idx);
    send_word({16'h0, 6'h0, node, 2'b01});
    @(negedge clk);
    if (exp_fail) begin
      chk(mem_wvalid == 1'b0, "R6 no write on empty", 32'(mem_wvalid), 32'h0);
      chk(rsp_valid && rsp_fail, "R6 fail reply", {30'h0, rsp_valid, rsp_fail}, 32'h3);
      chk(rsp_addr == 32'h0, "R6 fail address", rsp_addr, 32'h0);
    end else begin
      chk(mem_wvalid == 1'b1, "R4 write raised", 32'(mem_wvalid), 32'h1);
      chk(mem_waddr == ea, "R3 segment address", mem_waddr, ea);
      chk(mem_wdata == ctx_word(node, exp_idx), "R4 context word", mem_wdata, ctx_word(node, exp_idx));
      for (int k = 0; k < wst; k++) begin
        chk(!req_ready && !rsp_valid, "R10 busy during write", {30'h0, req_ready, rsp_valid}, 32'h0);
        @(negedge clk);
      end
      chk(mem_wvalid && mem_waddr == ea, "R4 write held", mem_waddr, ea);
      mem_wready = 1'b1;
      @(posedge clk);
      #1;
      mem_wready = 1'b0;
      @(negedge clk);
      chk(rsp_valid && !rsp_fail, "R5 reply after write", {30'h0, rsp_valid, rsp_fail}, 32'h2);
      chk(rsp_addr == ea, "R5 reply address", rsp_addr, ea);
    end
    chk(rsp_node == node, "R5 reply node", 32'(rsp_node), 32'(node));
    for (int k = 0; k < rst; k++) begin
      if (overlap && !exp_fail) begin
        req_valid = 1'b1;
        req_data  = {16'(exp_idx), 6'h0, node, 2'b10};
      end
      chk(!req_ready, "R10 request held off during reply stall", 32'(req_ready), 32'h0);
      @(negedge clk);
      chk(rsp_valid && rsp_addr == ea, "R5 reply held", rsp_addr, ea);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    rsp_ready = 1'b0;
    if (!exp_fail) begin
      void'(fq.pop_front());
      used_m[exp_idx] = 1'b1;
    end
    if (overlap && !exp_fail && rst > 0) begin
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after reply", 32'(req_ready), 32'h1);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      used_m[exp_idx] = 1'b0;
      fq.push_back(exp_idx);
      @(negedge clk);
      chk(rel_err == 1'b0, "R7 queued release accepted", 32'(rel_err), 32'h0);
    end
  endtask

  task automatic do_release(input int idx, input logic [7:0] node);
    bit bad;
    bad = !(idx < NSEG && used_m[idx]);
    send_word({16'(idx), 6'h2A, node, 2'b10});
    @(negedge clk);
    chk(rel_err == bad, bad ? "R8 rejected release flagged" : "R7 release no error",
        32'(rel_err), 32'(bad));
    chk(!rsp_valid && !mem_wvalid, "R7 release makes no reply or write",
        {30'h0, rsp_valid, mem_wvalid}, 32'h0);
    if (!bad) begin
      used_m[idx] = 1'b0;
      fq.push_back(idx);
    end
    @(negedge clk);
    chk(rel_err == 1'b0, "R8 error is one cycle", 32'(rel_err), 32'h0);
  endtask

  task automatic do_nop(input logic [1:0] op);
    send_word({16'h0003, 6'h0, 8'h55, op});
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_wvalid && !rel_err, "R9 unused opcode no effect",
        {28'h0, req_ready, rsp_valid, mem_wvalid, rel_err}, 32'h8);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NSEG; i++) begin
      fq.push_back(i);
      used_m[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(!rsp_valid && !mem_wvalid && !rel_err, "R1 idle outputs",
        {29'h0, rsp_valid, mem_wvalid, rel_err}, 32'h0);

    // Directed: first grants in ascending order (R2, R3)
    for (int i = 0; i < 4; i++) do_alloc(8'(8'h10 + i), i, 3 - i, 1'b0);
    do_release(1, 8'h10);
    do_release(1, 8'h10);          // R8 double release
    do_release(40, 8'h11);         // R8 out of range
    do_release(NSEG, 8'h11);       // R8 first index beyond pool
    do_release(9, 8'h12);          // R8 never granted
    do_nop(2'b00);
    do_nop(2'b11);

    // Drain the pool, then an allocate must fail (R6)
    while (fq.size() > 0) do_alloc(8'hA0, 0, 0, 1'b0);
    do_alloc(8'hA1, 0, 2, 1'b0);
    do_release(5, 8'hA2);
    do_release(2, 8'hA2);
    do_alloc(8'hA3, 1, 0, 1'b0);   // R3 oldest released index first
    do_alloc(8'hA4, 0, 0, 1'b0);

    // Overlap of held reply and pending request (R10)
    do_release(7, 8'hB0);
    do_alloc(8'hB1, 2, 4, 1'b1);
    do_alloc(8'hB2, 0, 1, 1'b0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 50) do_alloc(8'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
                           int'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0));
      else if (r < 92) do_release(int'($urandom_range(0, NSEG + 1)), 8'($urandom_range(0, 255)));
      else do_nop(($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule